// File: doc/BRIEF.md
# FEAC Codeword Receive Detector

This block watches a received far-end alarm and control (FEAC) serial stream and recovers the 6-bit codes that the far end sends. A codeword is 16 bits long, and the stream carries no framing beyond the codeword itself. The block therefore tests every received bit position as a possible codeword boundary until a valid codeword appears. From then on it checks the stream on 16-bit boundaries. Bits are taken only on clock cycles where the bit-enable strobe is high, so the line rate can be any fraction of the clock.

A code counts as detected once three error-free codewords in a row carry the same value. On detection the block raises a detected flag and issues a single write strobe, with the code, toward a receive FIFO that lies outside the block. The flag drops after two consecutive codewords that differ from the detected code, or when the line goes idle. The block declares idle after a run of all-ones and clears it when a new code is detected.

Top module: `feac_rx_detect`

## Requirements
- R1: A synchronous active-high reset clears `code_det`, `idle`, `fifo_wr` and `fifo_data`, and drops any alignment and match history.
- R2: Clock cycles with `bit_en` low consume no bit. On those cycles `fifo_wr` stays low, and `code_det` and `idle` hold their values whatever `bit_in` does.
- R3: In receive order a codeword is `0 C6 C5 C4 C3 C2 C1 0` followed by eight ones. Until alignment is found, a codeword ending at any bit position is accepted.
- R4: The third consecutive error-free codeword carrying the same code sets `code_det` and pulses `fifo_wr` for one cycle. Both are visible one clock after the enabled edge that takes the last bit of that codeword. Two such codewords are not enough.
- R5: `fifo_data` carries C1 in bit 0 and C6 in bit 5, which is the code in receive order with the first code bit as the most significant bit. The value only changes together with a `fifo_wr` pulse.
- R6: A code that is already detected and keeps arriving produces no further `fifo_wr` pulses.
- R7: While `code_det` is set, one codeword that differs from the detected code leaves the flag set. Two consecutive differing codewords clear it.
- R8: Once aligned, a 16-bit window at a codeword boundary that breaks the pattern counts as a differing codeword. It resets the match count to zero and sends the block back to searching at every bit position.
- R9: Sixteen consecutive received ones set `idle` and clear `code_det`. Fifteen ones do not set `idle`.
- R10: A new code detection clears `idle` in the same cycle that `code_det` is set.
- R11: After the flag has been cleared, a different code that is confirmed three times is detected and written, like any other detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` as a new received bit |
| bit_in | input | 1 | Received serial FEAC bit |
| code_det | output | 1 | Code-detected flag (registered) |
| idle | output | 1 | Idle condition flag (registered) |
| fifo_wr | output | 1 | One-cycle write strobe to the receive FIFO |
| fifo_data | output | 6 | Detected code, C1 in bit 0 and C6 in bit 5 |

## Verification
Every result of the block is registered at the enabled edge that takes the deciding bit: the final bit of a codeword, or the sixteenth one of an idle run. The result is therefore due exactly one clock after that edge. The bench drives each bit at a falling edge, holds `bit_en` for one cycle, and compares all outputs at the next falling edge. It then compares them again on every gap cycle, where nothing may change. Directed checks after whole codewords count the write pulses and the flag states seen at those sample points.

// File: rtl/feac_rx_pkg.sv
package feac_rx_pkg;

  typedef enum logic {
    ALN_HUNT   = 1'b0,
    ALN_LOCKED = 1'b1
  } aln_state_t;

endpackage

// File: rtl/feac_rx_align.sv
module feac_rx_align
  import feac_rx_pkg::*;
#(
  parameter int CW_LEN = 16,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              bit_in,
  output logic              cw_eval,
  output logic              cw_ok,
  output logic [CODE_W-1:0] cw_code
);

  localparam int FLAG_W = CW_LEN - CODE_W - 2;
  localparam int PH_W   = $clog2(CW_LEN);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CW_LEN - 1);

  logic [CW_LEN-1:0] win_q;
  logic [CW_LEN-1:0] win_nx;
  logic [PH_W-1:0]   phase_q;
  aln_state_t        st_q;
  logic              pat_ok;

  assign win_nx = {win_q[CW_LEN-2:0], bit_in};

  // start zero, code field, separator zero, then the all-ones flag
  assign pat_ok = !win_nx[CW_LEN-1] && !win_nx[FLAG_W] && (&win_nx[FLAG_W-1:0]);

  assign cw_ok   = pat_ok;
  assign cw_code = win_nx[CW_LEN-2 -: CODE_W];
  assign cw_eval = bit_en && ((st_q == ALN_LOCKED) ? (phase_q == PH_LAST) : pat_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= '1;
      phase_q <= '0;
      st_q    <= ALN_HUNT;
    end else if (bit_en) begin
      win_q <= win_nx;
      if (cw_eval) begin
        st_q    <= pat_ok ? ALN_LOCKED : ALN_HUNT;
        phase_q <= '0;
      end else if (st_q == ALN_LOCKED) begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/feac_rx_idle.sv
module feac_rx_idle #(
  parameter int IDLE_RUN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  input  logic det_set,
  output logic idle_set,
  output logic idle
);

  localparam int RUN_W = $clog2(IDLE_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(IDLE_RUN);
  localparam logic [RUN_W-1:0] RUN_PREV = RUN_W'(IDLE_RUN - 1);

  logic [RUN_W-1:0] run_q;

  assign idle_set = bit_en && bit_in && (run_q == RUN_PREV);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (bit_en) begin
      if (!bit_in)
        run_q <= '0;
      else if (run_q != RUN_MAX)
        run_q <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      idle <= 1'b0;
    else if (det_set)
      idle <= 1'b0;
    else if (idle_set)
      idle <= 1'b1;
  end

endmodule

// File: rtl/feac_rx_persist.sv
module feac_rx_persist #(
  parameter int CODE_W    = 6,
  parameter int CONFIRM_N = 3,
  parameter int CLEAR_N   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cw_eval,
  input  logic              cw_ok,
  input  logic [CODE_W-1:0] cw_code,
  input  logic              idle_set,
  output logic              det_set,
  output logic              code_det,
  output logic              fifo_wr,
  output logic [CODE_W-1:0] fifo_data
);

  localparam int CNT_W = $clog2(CONFIRM_N + 1);
  localparam int DIF_W = $clog2(CLEAR_N + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CONFIRM_N);
  localparam logic [CNT_W-1:0] CNT_PRE  = CNT_W'(CONFIRM_N - 1);
  localparam logic [DIF_W-1:0] DIF_PRE  = DIF_W'(CLEAR_N - 1);

  logic [CODE_W-1:0] cand_q;
  logic [CODE_W-1:0] det_code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nx;
  logic [DIF_W-1:0]  diff_q;
  logic              same_cand;
  logic              differs;
  logic              drop;

  assign same_cand = cw_ok && (cnt_q != '0) && (cw_code == cand_q);

  always_comb begin
    if (!cw_ok)
      cnt_nx = '0;
    else if (same_cand)
      cnt_nx = (cnt_q == CNT_FULL) ? cnt_q : cnt_q + 1'b1;
    else
      cnt_nx = CNT_W'(1);
  end

  assign det_set = cw_eval && cw_ok && (cnt_q == CNT_PRE) && (cnt_nx == CNT_FULL)
                   && !(code_det && (cw_code == det_code_q));
  assign differs = cw_eval && code_det && !(cw_ok && (cw_code == det_code_q));
  assign drop    = differs && (diff_q == DIF_PRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= '0;
      cnt_q  <= '0;
    end else if (cw_eval) begin
      if (cw_ok)
        cand_q <= cw_code;
      cnt_q <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_det   <= 1'b0;
      det_code_q <= '0;
      diff_q     <= '0;
    end else if (det_set) begin
      code_det   <= 1'b1;
      det_code_q <= cw_code;
      diff_q     <= '0;
    end else if (idle_set || drop) begin
      code_det <= 1'b0;
      diff_q   <= '0;
    end else if (cw_eval && code_det) begin
      diff_q <= differs ? diff_q + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr   <= 1'b0;
      fifo_data <= '0;
    end else begin
      fifo_wr <= det_set;
      if (det_set)
        fifo_data <= cw_code;
    end
  end

endmodule

// File: rtl/feac_rx_detect.sv
module feac_rx_detect #(
  parameter int CW_LEN    = 16,
  parameter int CODE_W    = 6,
  parameter int CONFIRM_N = 3,
  parameter int CLEAR_N   = 2,
  parameter int IDLE_RUN  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              bit_in,
  output logic              code_det,
  output logic              idle,
  output logic              fifo_wr,
  output logic [CODE_W-1:0] fifo_data
);

  logic              cw_eval;
  logic              cw_ok;
  logic [CODE_W-1:0] cw_code;
  logic              idle_set;
  logic              det_set;

  feac_rx_align #(
    .CW_LEN (CW_LEN),
    .CODE_W (CODE_W)
  ) align_i (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .bit_in  (bit_in),
    .cw_eval (cw_eval),
    .cw_ok   (cw_ok),
    .cw_code (cw_code)
  );

  feac_rx_persist #(
    .CODE_W    (CODE_W),
    .CONFIRM_N (CONFIRM_N),
    .CLEAR_N   (CLEAR_N)
  ) persist_i (
    .clk       (clk),
    .rst       (rst),
    .cw_eval   (cw_eval),
    .cw_ok     (cw_ok),
    .cw_code   (cw_code),
    .idle_set  (idle_set),
    .det_set   (det_set),
    .code_det  (code_det),
    .fifo_wr   (fifo_wr),
    .fifo_data (fifo_data)
  );

  feac_rx_idle #(
    .IDLE_RUN (IDLE_RUN)
  ) idle_i (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .bit_in   (bit_in),
    .det_set  (det_set),
    .idle_set (idle_set),
    .idle     (idle)
  );

endmodule

// File: rtl/feac_rx_detect_chk.sv
module feac_rx_detect_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_en,
  input logic              code_det,
  input logic              idle,
  input logic              fifo_wr,
  input logic [CODE_W-1:0] fifo_data
);

  // R4
  wr_has_det_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> code_det);

  // R4
  det_rise_wr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(code_det) |-> fifo_wr);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |=> !fifo_wr);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fifo_wr |-> $stable(fifo_data));

  // R2
  no_bit_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> (!fifo_wr && $stable(code_det) && $stable(idle)));

  // R9
  idle_clears_det_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(idle) |-> !code_det);

  // R10
  wr_ends_idle_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> !idle);

endmodule

bind feac_rx_detect feac_rx_detect_chk #(
  .CODE_W (CODE_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bit_en    (bit_en),
  .code_det  (code_det),
  .idle      (idle),
  .fifo_wr   (fifo_wr),
  .fifo_data (fifo_data)
);

// File: tb/feac_rx_detect_tb_top.sv
`timescale 1ns/1ps
module feac_rx_detect_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic       code_det, idle, fifo_wr;
  logic [5:0] fifo_data;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  bit gaps_on = 1'b0;
  int wr_seen = 0;

  // reference model state
  logic [15:0] mw;
  logic        mal, mdet, midle, exp_wr;
  int          mph, mcnt, mdiff, mones;
  logic [5:0]  mcand, mdcode, exp_data;

  always #2 clk = ~clk;

  feac_rx_detect dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .code_det(code_det), .idle(idle), .fifo_wr(fifo_wr), .fifo_data(fifo_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input logic [5:0] code);
    return {1'b0, code, 1'b0, 8'hFF};
  endfunction

  task automatic model_reset();
    mw = '1; mal = 0; mph = 0; mcnt = 0; mdiff = 0; mones = 0;
    mcand = 0; mdcode = 0; mdet = 0; midle = 0; exp_wr = 0; exp_data = 0;
  endtask

  task automatic model_step(input logic b);
    logic [15:0] nw;
    logic ok, ev;
    logic [5:0] code;
    int pc;
    nw = {mw[14:0], b};
    mw = nw;
    ok = !nw[15] && !nw[8] && (nw[7:0] == 8'hFF);
    code = nw[14:9];
    ev = mal ? (mph == 15) : ok;
    exp_wr = 0;
    if (b) begin
      if (mones == 15) begin midle = 1; mdet = 0; end
      if (mones < 16) mones++;
    end else mones = 0;
    if (!ev) begin
      if (mal) mph++;
    end else if (!ok) begin
      mal = 0; mcnt = 0;
      if (mdet) begin
        mdiff++;
        if (mdiff == 2) begin mdet = 0; mdiff = 0; end
      end
    end else begin
      mal = 1; mph = 0; pc = mcnt;
      if (mcnt != 0 && code == mcand) begin
        if (mcnt < 3) mcnt++;
      end else begin
        mcand = code; mcnt = 1;
      end
      if (mcnt == 3 && pc == 2 && !(mdet && code == mdcode)) begin
        mdet = 1; mdcode = code; mdiff = 0; exp_wr = 1; exp_data = code; midle = 0;
      end else if (mdet) begin
        if (code == mdcode) mdiff = 0;
        else begin
          mdiff++;
          if (mdiff == 2) begin mdet = 0; mdiff = 0; end
        end
      end
    end
  endtask

  task automatic compare_all();
    check(code_det == mdet,   "R7 code_det", code_det, mdet);
    check(idle == midle,      "R9 idle", idle, midle);
    check(fifo_wr == exp_wr,  "R6 fifo_wr", fifo_wr, exp_wr);
    check(fifo_data == exp_data, "R5 fifo_data", fifo_data, exp_data);
    if (fifo_wr) wr_seen++;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_en = 1'b1; bit_in = b;
    model_step(b);
    @(negedge clk);
    bit_en = 1'b0; bit_in = 1'($urandom % 2);
    compare_all();
    exp_wr = 0;
    if (gaps_on) begin
      repeat ($urandom % 3) begin
        bit_in = 1'($urandom % 2);
        @(negedge clk);
        compare_all();   // R2: nothing moves without bit_en
      end
    end
  endtask

  task automatic send_cw(input logic [5:0] code);
    logic [15:0] w;
    w = cw(code);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [5:0] a, b, c;
    int w0;
    void'($urandom(32'd1234));
    model_reset();
    a = 6'($urandom); b = a ^ 6'h15; c = a ^ 6'h2A;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(code_det == 0, "R1 code_det", code_det, 0);
    check(idle == 0, "R1 idle", idle, 0);
    check(fifo_wr == 0, "R1 fifo_wr", fifo_wr, 0);
    check(fifo_data == 0, "R1 fifo_data", fifo_data, 0);

    // R3/R4/R5: zero prefix at a random offset, then three codewords
    gaps_on = 1'b1;
    repeat (1 + $urandom % 15) send_bit(1'b0);
    send_cw(a); send_cw(a);
    check(code_det == 0, "R4 two not enough", code_det, 0);
    w0 = wr_seen;
    send_cw(a);
    check(code_det == 1, "R3 R4 detected", code_det, 1);
    check(wr_seen == w0 + 1, "R4 one write", wr_seen - w0, 1);
    check(fifo_data == a, "R5 mapping", fifo_data, a);

    // R6: repeats write nothing
    w0 = wr_seen;
    repeat (3) send_cw(a);
    check(wr_seen == w0, "R6 no rewrite", wr_seen - w0, 0);

    // R2: long stretch of disabled ones does not declare idle
    bit_in = 1'b1;
    repeat (20) @(negedge clk);
    check(idle == 0 && code_det == 1, "R2 ignored bits", {idle, code_det}, 1);

    // R7: single differing codeword, then two
    send_cw(b);
    check(code_det == 1, "R7 one differs", code_det, 1);
    send_cw(a);
    send_cw(b);
    check(code_det == 1, "R7 first of two", code_det, 1);
    send_cw(b);
    check(code_det == 0, "R7 cleared", code_det, 0);
    w0 = wr_seen;
    send_cw(b);
    check(code_det == 1 && fifo_data == b, "R11 new code", fifo_data, b);
    check(wr_seen == w0 + 1, "R11 write", wr_seen - w0, 1);

    // R9: idle after 16 ones, not 15
    send_bit(1'b0);
    repeat (15) send_bit(1'b1);
    check(idle == 0, "R9 fifteen ones", idle, 0);
    send_bit(1'b1);
    check(idle == 1, "R9 idle set", idle, 1);
    check(code_det == 0, "R9 det cleared", code_det, 0);

    // R8: broken codeword resets match count
    send_cw(c); send_cw(c);
    begin
      logic [15:0] bw;
      bw = cw(c) | 16'h0100;
      for (int i = 15; i >= 0; i--) send_bit(bw[i]);
    end
    send_cw(c); send_cw(c);
    check(code_det == 0, "R8 count reset", code_det, 0);
    send_cw(c);
    check(code_det == 1 && fifo_data == c, "R8 redetect", fifo_data, c);
    check(idle == 0, "R10 idle cleared", idle, 0);

    // random traffic against the model
    for (int n = 0; n < 300; n++) begin
      logic [5:0] pick;
      logic [15:0] w;
      int sel;
      sel = $urandom % 3;
      pick = (sel == 0) ? a : (sel == 1) ? b : c;
      if ($urandom % 16 == 0) begin
        repeat (17) send_bit(1'b1);
      end
      w = cw(pick);
      if ($urandom % 8 == 0) w[$urandom % 16] ^= 1'b1;
      for (int i = 15; i >= 0; i--) send_bit(w[i]);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule